// File: doc/BRIEF.md
# Shared interrupt line router

This block collects level-sensitive interrupt requests from a set of device slots and presents them as a 16-bit vector of legacy interrupt request inputs. Each slot reports a change on one of its four interrupt pins. The report carries the slot number, the pin and the new level. The block folds the pin with the slot number onto one of four shared lines, so that neighbouring slots spread their first pin over different lines.

For every shared line the block keeps one level bit per slot. A line is active while any slot holds a request on it. Four 8-bit steering registers each send one shared line to a legacy IRQ number, or to none. Each legacy IRQ output is the OR of every active line steered to it, so two or more lines can share one IRQ. Software loads the steering registers and reads them back through a small register port.

Top module: `pci_intx_router`

## Requirements
- R1: After reset every steering register reads 0x80 and all 16 IRQ outputs are low.
- R2: A report from slot `s` on pin `p` (pin code 0..3 for the first to the fourth pin) lands on shared line `(p + s + 3) mod 4`. The line is the same as `(p + s - 1) mod 4`.
- R3: A shared line stays active while at least one slot holds its bit set. Clearing one slot's bit does not drop the line while another slot's bit on that line is still set.
- R4: A steering value from 0 to 15 sends its line to the IRQ output of that number. Any value of 16 or above keeps the line off every output.
- R5: Each IRQ output is the OR of all active shared lines whose steering registers hold its number.
- R6: A steering write with `cfg_sel` picking register 0..3 (register n steers line n) reads back as the full 8-bit value. The new steering shows on `irq_out` in the cycle after the write edge, and level reports show there in the same way.
- R7: A report whose slot number is not below `NUM_SLOTS` changes no level bit and no output.
- R8: `irq_out` changes only after a cycle that carried a level report or a steering write. Outputs that a steering write does not involve keep their value across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_valid | input | 1 | A level report is present this cycle |
| dev_slot | input | SLOT_W | Slot number of the reporting device |
| dev_pin | input | 2 | Pin code 0..3 |
| dev_level | input | 1 | New level of that pin |
| cfg_we | input | 1 | Steering register write strobe |
| cfg_sel | input | 2 | Steering register index for write and read |
| cfg_wdata | input | 8 | Steering value to write |
| cfg_rdata | output | 8 | Current value of the selected steering register |
| irq_out | output | 16 | Legacy IRQ request vector |

## Verification
The bench builds two instances. One uses the default 32 slots, where every slot code is valid and slot 31 tests the wrap of the pin fold. The other uses 6 slots. That leaves codes 6 and 7 out of range, so the rejection of such reports can be observed at the outputs. The non-power-of-two range check is the variant that only this second build elaborates.

// File: rtl/pir_pkg.sv
package pir_pkg;
   localparam int LINES   = 4;
   localparam int LINE_W  = 2;
   localparam int IRQS    = 16;
   localparam int ROUTE_W = 8;

   typedef logic [LINE_W-1:0]  line_t;
   typedef logic [ROUTE_W-1:0] route_t;

   // Fold a pin onto a shared line: (pin + slot - 1) mod 4; only the two
   // low slot bits matter for a modulo-4 result.
   function automatic line_t fold_line(input logic [1:0] pin, input logic [1:0] slot_lo);
      return line_t'(pin + slot_lo - 2'd1);
   endfunction
endpackage

// File: rtl/pir_level_store.sv
module pir_level_store
   import pir_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int SLOT_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [SLOT_W-1:0] evt_slot,
   input  logic [1:0]        evt_pin,
   input  logic              evt_level,
   output logic [LINES-1:0]  line_lvl
);
   logic  in_range;
   line_t tgt_line;
   logic [NUM_SLOTS-1:0] slot_mask;

   generate
      if (NUM_SLOTS == (1 << SLOT_W)) begin : g_full_range
         assign in_range = 1'b1;
      end else begin : g_part_range
         assign in_range = ({1'b0, evt_slot} < (SLOT_W+1)'(NUM_SLOTS));
      end
   endgenerate

   assign tgt_line  = fold_line(evt_pin, evt_slot[1:0]);
   assign slot_mask = in_range ? (NUM_SLOTS'(1) << evt_slot) : '0;

   generate
      for (genvar l = 0; l < LINES; l++) begin : g_line
         logic [NUM_SLOTS-1:0] held;
         logic                 hit;
         assign hit = evt_valid && (tgt_line == line_t'(l));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held <= '0;
            else if (hit)
               held <= evt_level ? (held | slot_mask) : (held & ~slot_mask);
         end
         assign line_lvl[l] = |held;
      end
   endgenerate

   // R3: a raised report shows on its line after the edge
   a_r3_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && in_range && evt_level) |=> line_lvl[$past(tgt_line)]);

   // R7: out-of-range reports leave every line untouched
   a_r7_ignore_oob: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !in_range) |=> $stable(line_lvl));
endmodule

// File: rtl/pir_route_bank.sv
module pir_route_bank
   import pir_pkg::*;
#(
   parameter logic [7:0] RESET_VAL = 8'h80
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [LINE_W-1:0]       sel,
   input  route_t                  wdata,
   output route_t                  rdata,
   output logic [LINES-1:0][ROUTE_W-1:0] route
);
   generate
      for (genvar l = 0; l < LINES; l++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               route[l] <= RESET_VAL;
            else if (we && sel == LINE_W'(l))
               route[l] <= wdata;
         end
      end
   endgenerate

   assign rdata = route[sel];

   // R6: a write lands in the selected register
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (route[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/pir_irq_merge.sv
module pir_irq_merge
   import pir_pkg::*;
(
   input  logic [LINES-1:0]              line_lvl,
   input  logic [LINES-1:0][ROUTE_W-1:0] route,
   output logic [IRQS-1:0]               irq
);
   generate
      for (genvar k = 0; k < IRQS; k++) begin : g_irq
         logic [LINES-1:0] hit;
         for (genvar l = 0; l < LINES; l++) begin : g_src
            // a full 8-bit compare makes any value >= 16 match nothing
            assign hit[l] = line_lvl[l] && (route[l] == ROUTE_W'(k));
         end
         assign irq[k] = |hit;
      end
   endgenerate
endmodule

// File: rtl/pci_intx_router.sv
module pci_intx_router
   import pir_pkg::*;
#(
   parameter int         NUM_SLOTS   = 32,
   parameter int         SLOT_W      = $clog2(NUM_SLOTS),
   parameter logic [7:0] ROUTE_RESET = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_valid,
   input  logic [SLOT_W-1:0] dev_slot,
   input  logic [1:0]        dev_pin,
   input  logic              dev_level,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic [15:0]       irq_out
);
   generate
      if (NUM_SLOTS < 4 || NUM_SLOTS > 256)
         $error("NUM_SLOTS must lie in 4..256");
      if (SLOT_W != $clog2(NUM_SLOTS))
         $error("SLOT_W must equal clog2(NUM_SLOTS)");
   endgenerate

   logic [LINES-1:0]              line_lvl;
   logic [LINES-1:0][ROUTE_W-1:0] route;

   pir_level_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(dev_valid), .evt_slot(dev_slot), .evt_pin(dev_pin),
      .evt_level(dev_level), .line_lvl(line_lvl));

   pir_route_bank #(.RESET_VAL(ROUTE_RESET)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .route(route));

   pir_irq_merge u_merge (
      .line_lvl(line_lvl), .route(route), .irq(irq_out));

   // R5: an active line steered to IRQ n keeps output n high
   generate
      for (genvar l = 0; l < LINES; l++) begin : g_chk
         a_r5_line_reaches_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (line_lvl[l] && route[l] < 8'd16) |-> irq_out[route[l][3:0]]);
      end
   endgenerate

   // R8: with no report and no write the output vector holds
   a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && !dev_valid) |=> $stable(irq_out));
endmodule

// File: tb/pci_intx_router_tb.sv
`timescale 1ns/1ps
module pci_intx_router_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       dv = 0, dl = 0, cwe = 0;
   logic [4:0] ds = 0;
   logic [1:0] dp = 0, csel = 0;
   logic [7:0] cwd = 0, crd;
   logic [15:0] irq;

   logic       dv6 = 0, dl6 = 0, cwe6 = 0;
   logic [2:0] ds6 = 0;
   logic [1:0] dp6 = 0, csel6 = 0;
   logic [7:0] cwd6 = 0, crd6;
   logic [15:0] irq6;

   int checks = 0, errors = 0;
   bit done = 0;

   pci_intx_router u_dut (.clk(clk), .rst_n(rst_n), .dev_valid(dv), .dev_slot(ds),
      .dev_pin(dp), .dev_level(dl), .cfg_we(cwe), .cfg_sel(csel), .cfg_wdata(cwd),
      .cfg_rdata(crd), .irq_out(irq));

   pci_intx_router #(.NUM_SLOTS(6)) u_dut6 (.clk(clk), .rst_n(rst_n), .dev_valid(dv6),
      .dev_slot(ds6), .dev_pin(dp6), .dev_level(dl6), .cfg_we(cwe6), .cfg_sel(csel6),
      .cfg_wdata(cwd6), .cfg_rdata(crd6), .irq_out(irq6));

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int sel, int val);
      @(negedge clk); cwe = 1; csel = 2'(sel); cwd = 8'(val);
      @(negedge clk); cwe = 0;
   endtask

   task automatic evt(int slot, int pin, bit lvl);
      @(negedge clk); dv = 1; ds = 5'(slot); dp = 2'(pin); dl = lvl;
      @(negedge clk); dv = 0;
   endtask

   task automatic wr6(int sel, int val);
      @(negedge clk); cwe6 = 1; csel6 = 2'(sel); cwd6 = 8'(val);
      @(negedge clk); cwe6 = 0;
   endtask

   task automatic evt6(int slot, int pin, bit lvl);
      @(negedge clk); dv6 = 1; ds6 = 3'(slot); dp6 = 2'(pin); dl6 = lvl;
      @(negedge clk); dv6 = 0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 4; i++) begin
         csel = 2'(i); csel6 = 2'(i); #0.5;
         chk("R1 steering reset", 16'(crd), 16'h0080);
         chk("R1 steering reset 6-slot", 16'(crd6), 16'h0080);
      end
      chk("R1 irq reset", irq, 16'h0000);
   endtask

   task automatic t_readback;
      wr(0, 8'h5A); wr(3, 8'hC3);
      csel = 0; #0.5; chk("R6 readback reg0", 16'(crd), 16'h005A);
      csel = 3; #0.5; chk("R6 readback reg3", 16'(crd), 16'h00C3);
   endtask

   task automatic t_rotation;
      for (int l = 0; l < 4; l++) wr(l, 3 + l);
      evt(1, 0, 1); chk("R2 slot1 pin0 -> line0", irq, 16'h0008);
      evt(1, 0, 0); chk("R2 clear", irq, 16'h0000);
      evt(2, 0, 1); chk("R2 slot2 pin0 -> line1", irq, 16'h0010);
      evt(2, 0, 0);
      evt(0, 0, 1); chk("R2 slot0 pin0 -> line3", irq, 16'h0040);
      evt(0, 0, 0);
      evt(31, 3, 1); chk("R2 slot31 pin3 -> line1", irq, 16'h0010);
      evt(31, 3, 0); chk("R2 clear", irq, 16'h0000);
   endtask

   task automatic t_multi;
      evt(1, 0, 1); evt(5, 0, 1);
      chk("R3 two devices on line0", irq, 16'h0008);
      evt(1, 0, 0); chk("R3 line held by slot5", irq, 16'h0008);
      evt(1, 1, 1); evt(1, 1, 0); chk("R3 other pin of slot1", irq, 16'h0008);
      evt(5, 0, 0); chk("R3 line dropped", irq, 16'h0000);
   endtask

   task automatic t_disable;
      wr(0, 8'h10); evt(1, 0, 1);
      chk("R4 value 16 disables", irq, 16'h0000);
      wr(0, 8'hFF); chk("R4 value 0xFF disables", irq, 16'h0000);
      wr(0, 15); chk("R4 IRQ15", irq, 16'h8000);
      wr(0, 0); chk("R4 IRQ0", irq, 16'h0001);
      evt(1, 0, 0);
   endtask

   task automatic t_share;
      wr(0, 7); wr(1, 7); wr(2, 8'h80); wr(3, 8'h80);
      evt(2, 0, 1); chk("R5 line1 on IRQ7", irq, 16'h0080);
      evt(1, 0, 1); chk("R5 both lines on IRQ7", irq, 16'h0080);
      evt(2, 0, 0); chk("R5 line0 keeps IRQ7", irq, 16'h0080);
      evt(1, 0, 0); chk("R5 IRQ7 drops", irq, 16'h0000);
   endtask

   task automatic t_glitch;
      logic [15:0] snap;
      wr(0, 3); wr(1, 4);
      evt(1, 0, 1); evt(2, 0, 1);
      chk("R5 two outputs", irq, 16'h0018);
      @(negedge clk); cwe = 1; csel = 1; cwd = 8;
      #1; chk("R6 no change before edge", irq, 16'h0018);
      @(negedge clk); cwe = 0;
      chk("R6 moved next cycle", irq, 16'h0108);
      chk("R8 IRQ3 untouched", 16'(irq[3]), 16'h0001);
      snap = irq;
      repeat (5) @(negedge clk);
      chk("R8 idle hold", irq, snap);
      evt(1, 0, 0); evt(2, 0, 0);
   endtask

   task automatic t_oob;
      for (int l = 0; l < 4; l++) wr6(l, 1 + l);
      evt6(7, 0, 1); chk("R7 slot7 ignored", irq6, 16'h0000);
      evt6(6, 1, 1); chk("R7 slot6 ignored", irq6, 16'h0000);
      evt6(5, 1, 1); chk("R7 slot5 accepted", irq6, 16'h0004);
      evt6(7, 3, 0); chk("R7 oob clear ignored", irq6, 16'h0004);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1;
      @(negedge clk);
      t_readback;
      t_rotation;
      t_multi;
      t_disable;
      t_share;
      t_glitch;
      t_oob;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule